// File: doc/BRIEF.md
# Priority Column Readout Controller

This controller drains hit data from a column of pixel cells. Every cell raises a read request once it holds a hit. While the request is pending the cell shows three values: its row number, the time at which its pulse began and the time at which it ended. Both times are 8-bit Gray-coded stamps. The controller picks one requesting cell at a time by fixed priority and selects that cell with a one-hot read line. It then produces one hit record and offers it downstream on a valid/ready handshake.

A record holds four fields:

- the column number, which the controller supplies itself;
- the row number taken from the cell;
- the start time converted to binary;
- the pulse duration, computed as the binary end time minus the binary start time, wrapping at 256.

A freeze output stays high while a transfer is open. During that time the chosen cell and the offered record cannot change, even if a cell of higher priority captures a new hit.

When the record is accepted, the read line drops and the controller spends one cycle idle so the served cell can withdraw its request. It then arbitrates again among the remaining requesters.

Top module: `col_readout_ctrl`

## Requirements
- R1: While reset is held, and until the first grant after release, `out_valid_o`, `freeze_o` and every bit of `read_o` are 0.
- R2: Among requesting cells, the lowest index always wins the grant. `read_o` is one-hot, with bit i selecting cell i.
- R3: From the grant until the record is accepted, the following stay high and unchanged, whatever the other request lines do: `freeze_o`, the selected `read_o` bit and the record fields.
- R4: On the clock edge where `out_valid_o` and `out_ready_i` are both 1, three things happen: `out_valid_o` falls, `read_o` goes to all zeros and `freeze_o` falls. The next record becomes valid on the second edge after that acceptance edge, and it belongs to the lowest-index cell still requesting.
- R5: `out_le_o` is the binary value of the selected cell's Gray start stamp. Binary bit i is the XOR of the Gray bits from bit i up to the top bit.
- R6: `out_tot_o` equals the binary end time minus the binary start time, modulo 2^TS_W. This includes a pulse that spans a wrap of the stamp, and a duration of zero when both stamps are equal.
- R7: `out_col_o` is the value on `col_addr_i` at the grant. `out_row_o` is the row value of the granted cell.
- R8: With no request pending, `out_valid_o` stays 0 and `read_o` stays all zeros.
- R9: While `out_valid_o` is 1 and `out_ready_i` is 0, `out_valid_o` stays 1 and the record holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside |
| col_addr_i | input | COL_W | Column number placed into every record |
| req_i | input | N | Read request, one bit per cell |
| row_i | input | N*ROW_W | Row number of each cell, cell i at bits [i*ROW_W +: ROW_W] |
| le_gray_i | input | N*TS_W | Gray start stamp of each cell, cell i at bits [i*TS_W +: TS_W] |
| te_gray_i | input | N*TS_W | Gray end stamp of each cell, same packing |
| read_o | output | N | One-hot read select of the granted cell |
| freeze_o | output | 1 | High while a transfer is open; no other cell may drive data |
| out_valid_o | output | 1 | Record valid |
| out_ready_i | input | 1 | Downstream ready |
| out_col_o | output | COL_W | Record column |
| out_row_o | output | ROW_W | Record row |
| out_le_o | output | TS_W | Record start time, binary |
| out_tot_o | output | TS_W | Record pulse duration |

## Verification
A request presented before a clock edge while the controller is idle produces a valid record just after that edge. The same edge drives the one-hot read line and the freeze output. Acceptance clears all three on its own edge. The next cell's record then appears two edges later, because one idle cycle lets the served cell drop its request.

The bench drives inputs on falling edges and samples on the falling edge that follows exactly that number of rising edges. When it holds back-pressure, it re-reads the record and the grant on every cycle of the hold.

// File: rtl/cr_pkg.sv
package cr_pkg;

  typedef enum logic [1:0] {
    CR_IDLE = 2'd0,
    CR_BUSY = 2'd1,
    CR_GAP  = 2'd2
  } cr_state_e;

endpackage

// File: rtl/cr_gray2bin.sv
module cr_gray2bin #(
  parameter int W = 8
) (
  input  logic [W-1:0] gray_i,
  output logic [W-1:0] bin_o
);

  // each binary bit folds every Gray bit from itself upward
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign bin_o[i] = ^gray_i[W-1:i];
  end

endmodule

// File: rtl/cr_prio_arb.sv
module cr_prio_arb #(
  parameter int N     = 8,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req_i,
  output logic [N-1:0]     gnt_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);

  logic [N:0] seen;

  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign gnt_o[i]    = req_i[i] & ~seen[i];
    assign seen[i + 1] = seen[i] | req_i[i];
  end

  assign any_o = seen[N];

  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end

endmodule

// File: rtl/cr_hit_builder.sv
module cr_hit_builder #(
  parameter int N     = 8,
  parameter int TS_W  = 8,
  parameter int ROW_W = 5,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [IDX_W-1:0]  sel_i,
  input  logic [N*ROW_W-1:0] row_i,
  input  logic [N*TS_W-1:0]  le_gray_i,
  input  logic [N*TS_W-1:0]  te_gray_i,
  output logic [ROW_W-1:0]   row_o,
  output logic [TS_W-1:0]    le_bin_o,
  output logic [TS_W-1:0]    tot_o
);

  logic [TS_W-1:0] le_gray_sel;
  logic [TS_W-1:0] te_gray_sel;
  logic [TS_W-1:0] te_bin;

  assign le_gray_sel = le_gray_i[sel_i * TS_W +: TS_W];
  assign te_gray_sel = te_gray_i[sel_i * TS_W +: TS_W];
  assign row_o       = row_i[sel_i * ROW_W +: ROW_W];

  cr_gray2bin #(.W(TS_W)) i_le_dec (
    .gray_i (le_gray_sel),
    .bin_o  (le_bin_o)
  );

  cr_gray2bin #(.W(TS_W)) i_te_dec (
    .gray_i (te_gray_sel),
    .bin_o  (te_bin)
  );

  // width-limited subtraction wraps naturally modulo 2^TS_W
  assign tot_o = te_bin - le_bin_o;

endmodule

// File: rtl/col_readout_ctrl.sv
module col_readout_ctrl #(
  parameter int N     = 8,
  parameter int TS_W  = 8,
  parameter int ROW_W = 5,
  parameter int COL_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [COL_W-1:0]   col_addr_i,
  input  logic [N-1:0]       req_i,
  input  logic [N*ROW_W-1:0] row_i,
  input  logic [N*TS_W-1:0]  le_gray_i,
  input  logic [N*TS_W-1:0]  te_gray_i,
  output logic [N-1:0]       read_o,
  output logic               freeze_o,
  output logic               out_valid_o,
  input  logic               out_ready_i,
  output logic [COL_W-1:0]   out_col_o,
  output logic [ROW_W-1:0]   out_row_o,
  output logic [TS_W-1:0]    out_le_o,
  output logic [TS_W-1:0]    out_tot_o
);

  import cr_pkg::*;

  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end

  assign rst_int_n = rst_sync_q[1];

  // arbitration and record assembly
  logic [N-1:0]     gnt;
  logic [IDX_W-1:0] gnt_idx;
  logic             any_req;
  logic [ROW_W-1:0] row_sel;
  logic [TS_W-1:0]  le_sel;
  logic [TS_W-1:0]  tot_sel;

  cr_prio_arb #(.N(N), .IDX_W(IDX_W)) i_arb (
    .req_i (req_i),
    .gnt_o (gnt),
    .idx_o (gnt_idx),
    .any_o (any_req)
  );

  cr_hit_builder #(.N(N), .TS_W(TS_W), .ROW_W(ROW_W), .IDX_W(IDX_W)) i_build (
    .sel_i     (gnt_idx),
    .row_i     (row_i),
    .le_gray_i (le_gray_i),
    .te_gray_i (te_gray_i),
    .row_o     (row_sel),
    .le_bin_o  (le_sel),
    .tot_o     (tot_sel)
  );

  // control
  cr_state_e state_q, state_d;
  logic      load_en;
  logic      accept;

  assign accept  = (state_q == CR_BUSY) && out_ready_i;
  assign load_en = (state_q == CR_IDLE) && any_req;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      CR_IDLE: if (any_req) state_d = CR_BUSY;
      CR_BUSY: if (out_ready_i) state_d = CR_GAP;
      CR_GAP:  state_d = CR_IDLE;
      default: state_d = CR_IDLE;
    endcase
  end

  logic [N-1:0] grant_q, grant_d;

  always_comb begin
    grant_d = grant_q;
    if (load_en)     grant_d = gnt;
    else if (accept) grant_d = '0;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= CR_IDLE;
      grant_q <= '0;
    end else begin
      state_q <= state_d;
      grant_q <= grant_d;
    end
  end

  // record payload: no reset, loaded only on grant
  logic [COL_W-1:0] col_q;
  logic [ROW_W-1:0] row_q;
  logic [TS_W-1:0]  le_q;
  logic [TS_W-1:0]  tot_q;

  always_ff @(posedge clk) begin
    if (load_en) begin
      col_q <= col_addr_i;
      row_q <= row_sel;
      le_q  <= le_sel;
      tot_q <= tot_sel;
    end
  end

  assign read_o      = grant_q;
  assign out_valid_o = (state_q == CR_BUSY);
  assign freeze_o    = (state_q == CR_BUSY);
  assign out_col_o   = col_q;
  assign out_row_o   = row_q;
  assign out_le_o    = le_q;
  assign out_tot_o   = tot_q;

endmodule

// File: rtl/cr_readout_checker.sv
module cr_readout_checker #(
  parameter int N     = 8,
  parameter int TS_W  = 8,
  parameter int ROW_W = 5,
  parameter int COL_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N-1:0]     req_i,
  input logic [N-1:0]     read_o,
  input logic             freeze_o,
  input logic             out_valid_o,
  input logic             out_ready_i,
  input logic [COL_W-1:0] out_col_o,
  input logic [ROW_W-1:0] out_row_o,
  input logic [TS_W-1:0]  out_le_o,
  input logic [TS_W-1:0]  out_tot_o
);

  localparam logic [N-1:0] ONE = N'(1);

  p_onehot_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(read_o));

  p_lowest_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid_o) |-> (((read_o & $past(req_i)) != '0) &&
                            (((read_o - ONE) & $past(req_i)) == '0)));

  p_freeze_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> (freeze_o && (read_o != '0)));

  p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && out_ready_i) |=> (!out_valid_o && !freeze_o && (read_o == '0)));

  p_no_grant_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid_o |-> (read_o == '0));

  p_stall_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(read_o) &&
      $stable(out_col_o) && $stable(out_row_o) && $stable(out_le_o) &&
      $stable(out_tot_o)));

endmodule

bind col_readout_ctrl cr_readout_checker #(
  .N(N), .TS_W(TS_W), .ROW_W(ROW_W), .COL_W(COL_W)
) i_cr_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_i       (req_i),
  .read_o      (read_o),
  .freeze_o    (freeze_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_col_o   (out_col_o),
  .out_row_o   (out_row_o),
  .out_le_o    (out_le_o),
  .out_tot_o   (out_tot_o)
);

// File: tb/test_col_readout_ctrl.sv
`timescale 1ns/1ps
module test_col_readout_ctrl;

  localparam int N     = 8;
  localparam int TS_W  = 8;
  localparam int ROW_W = 5;
  localparam int COL_W = 6;

  logic               clk;
  logic               rst_n;
  logic [COL_W-1:0]   col_addr;
  logic [N-1:0]       req;
  logic [N*ROW_W-1:0] row_flat;
  logic [N*TS_W-1:0]  le_flat;
  logic [N*TS_W-1:0]  te_flat;
  logic [N-1:0]       read_sel;
  logic               freeze;
  logic               valid;
  logic               ready;
  logic [COL_W-1:0]   col_out;
  logic [ROW_W-1:0]   row_out;
  logic [TS_W-1:0]    le_out;
  logic [TS_W-1:0]    tot_out;

  logic [TS_W-1:0]  le_b  [N];
  logic [TS_W-1:0]  te_b  [N];
  logic [ROW_W-1:0] row_b [N];

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  col_readout_ctrl #(.N(N), .TS_W(TS_W), .ROW_W(ROW_W), .COL_W(COL_W)) i_col_readout_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .col_addr_i  (col_addr),
    .req_i       (req),
    .row_i       (row_flat),
    .le_gray_i   (le_flat),
    .te_gray_i   (te_flat),
    .read_o      (read_sel),
    .freeze_o    (freeze),
    .out_valid_o (valid),
    .out_ready_i (ready),
    .out_col_o   (col_out),
    .out_row_o   (row_out),
    .out_le_o    (le_out),
    .out_tot_o   (tot_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [TS_W-1:0] to_gray(logic [TS_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  always_comb begin
    for (int i = 0; i < N; i++) begin
      le_flat[i*TS_W +: TS_W]    = to_gray(le_b[i]);
      te_flat[i*TS_W +: TS_W]    = to_gray(te_b[i]);
      row_flat[i*ROW_W +: ROW_W] = row_b[i];
    end
  end

  task automatic chk(string tag, bit ok, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic set_cell(int i, int le, int te, int row);
    le_b[i]  = TS_W'(le);
    te_b[i]  = TS_W'(te);
    row_b[i] = ROW_W'(row);
  endtask

  // expects a record from cell idx at the current falling edge; accepts it
  task automatic take_record(int idx);
    logic [TS_W-1:0] exp_tot;
    exp_tot = te_b[idx] - le_b[idx];
    chk("R2 grant",   read_sel == N'(1 << idx), int'(read_sel), 1 << idx);
    chk("R3 freeze",  freeze == 1'b1, int'(freeze), 1);
    chk("R4 valid",   valid == 1'b1, int'(valid), 1);
    chk("R5 le",      le_out == le_b[idx], int'(le_out), int'(le_b[idx]));
    chk("R6 tot",     tot_out == exp_tot, int'(tot_out), int'(exp_tot));
    chk("R7 col",     col_out == col_addr, int'(col_out), int'(col_addr));
    chk("R7 row",     row_out == row_b[idx], int'(row_out), int'(row_b[idx]));
    ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    ready = 1'b0;
    chk("R4 drop valid", valid == 1'b0, int'(valid), 0);
    chk("R4 drop read",  read_sel == '0, int'(read_sel), 0);
    chk("R4 drop freeze", freeze == 1'b0, int'(freeze), 0);
    req[idx] = 1'b0;
  endtask

  task automatic next_slot();
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    ready = 1'b0;
    req   = '0;
    col_addr = 6'd17;
    for (int i = 0; i < N; i++) set_cell(i, 0, 0, 0);
    repeat (3) @(negedge clk);
    chk("R1 valid in reset",  valid == 1'b0, int'(valid), 0);
    chk("R1 read in reset",   read_sel == '0, int'(read_sel), 0);
    chk("R1 freeze in reset", freeze == 1'b0, int'(freeze), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 valid after release", valid == 1'b0, int'(valid), 0);
    chk("R1 read after release",  read_sel == '0, int'(read_sel), 0);
  endtask

  task automatic t_idle();
    settle();
    for (int k = 0; k < 5; k++) begin
      chk("R8 idle valid", valid == 1'b0, int'(valid), 0);
      chk("R8 idle read",  read_sel == '0, int'(read_sel), 0);
      @(negedge clk);
    end
  endtask

  task automatic t_single_decode();
    settle();
    col_addr = 6'd42;
    set_cell(3, 8'hA5, 8'hF0, 19);
    req[3] = 1'b1;
    @(posedge clk);
    @(negedge clk);
    take_record(3);
  endtask

  task automatic t_wrap_and_zero();
    settle();
    col_addr = 6'd5;
    set_cell(0, 250, 4, 7);
    set_cell(7, 8'h3C, 8'h3C, 30);
    req[0] = 1'b1;
    req[7] = 1'b1;
    @(posedge clk);
    @(negedge clk);
    take_record(0);
    next_slot();
    take_record(7);
  endtask

  task automatic t_priority_order();
    settle();
    col_addr = 6'd63;
    set_cell(2, 10, 20, 2);
    set_cell(4, 100, 131, 4);
    set_cell(6, 200, 255, 6);
    req[6] = 1'b1;
    req[2] = 1'b1;
    req[4] = 1'b1;
    @(posedge clk);
    @(negedge clk);
    take_record(2);
    next_slot();
    take_record(4);
    next_slot();
    take_record(6);
    next_slot();
    chk("R8 empty after drain", valid == 1'b0, int'(valid), 0);
  endtask

  task automatic t_freeze_stall();
    settle();
    col_addr = 6'd9;
    set_cell(5, 40, 47, 21);
    set_cell(1, 60, 66, 11);
    req[5] = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req[1] = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R3 grant kept", read_sel == N'(1 << 5), int'(read_sel), 1 << 5);
      chk("R3 freeze kept", freeze == 1'b1, int'(freeze), 1);
      chk("R9 valid held", valid == 1'b1, int'(valid), 1);
      chk("R9 row held", row_out == row_b[5], int'(row_out), int'(row_b[5]));
      chk("R9 tot held", tot_out == 8'd7, int'(tot_out), 7);
    end
    take_record(5);
    next_slot();
    take_record(1);
  endtask

  initial begin
    rst_n = 1'b0;
    t_reset();
    t_idle();
    t_single_decode();
    t_wrap_and_zero();
    t_priority_order();
    t_freeze_stall();
    t_idle();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule